// File: doc/BRIEF.md
# Three-Wire Host Address Decoder

This block is the device side of a three-wire serial control bus driven by a microcontroller. The three wires are a serial clock, a data line and a mode line. A static strap pin picks one of two device addresses. When the mode line is low, the host sends an 8-bit address byte, least significant bit first, one bit per rising edge of the serial clock. After the eighth bit, the block decides whether it is the target. It also latches the 2-bit transfer type that comes with the address, and it sets the output enable of the bidirectional data line.

The three bus signals are brought into the system clock domain through a synchronizer. Bits are taken on the rising edges of the synchronized serial clock. Bits 7 down to 2 of the byte form the device address. Any address other than the one selected by the strap releases the data line and deselects the block. This includes the all-zero address, which is reserved for deselecting every device on the bus. While the block is selected, serial clocks that arrive with the mode line high belong to the data transfer phase. Each one is forwarded as a one-cycle strobe, together with the sampled data bit, to the register logic that sits downstream.

Top module: `hab_top`

## Requirements
- R1: After a synchronous reset, `sel_o` is 0, `data_oe_o` is 0, `xfer_type_o` is 2'b00, and no `xfer_stb_o` strobe is produced.
- R2: The first bit received in an addressing phase becomes bit 0 of the byte. Bits [1:0] are the transfer type. Bits [7:2] are the device address, with bit 7 as its MSB.
- R3: With `addr_sel_i` = 0, a completed byte whose device address is 6'b000001 sets `sel_o` to 1 and latches bits [1:0] into `xfer_type_o`.
- R4: With `addr_sel_i` = 1, a completed byte whose device address is 6'b000010 sets `sel_o` to 1 and latches bits [1:0] into `xfer_type_o`.
- R5: A completed byte with any other nonzero device address clears `sel_o` and `data_oe_o`, and sets `xfer_type_o` to 2'b00.
- R6: A completed byte with device address 6'b000000 clears `sel_o` and `data_oe_o`, whatever the value of `addr_sel_i`.
- R7: An addressing phase in which the mode line rises before the eighth bit leaves `sel_o`, `data_oe_o` and `xfer_type_o` unchanged.
- R8: When the block is selected, `data_oe_o` equals bit 1 of the latched transfer type (1 means the device drives the data line). When the block is not selected, `data_oe_o` is 0.
- R9: While the block is selected, each serial clock rising edge that arrives with the mode line high produces exactly one `xfer_stb_o` pulse. `xfer_bit_o` carries the data bit sampled at that edge. While the block is deselected, no pulse is produced.
- R10: Serial clocks beyond the eighth within one low period of the mode line are ignored. The decision made at the eighth bit stands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| bus_mode_i | input | 1 | Mode line: low means addressing phase, high means data phase |
| bus_data_i | input | 1 | Input side of the bidirectional data line |
| addr_sel_i | input | 1 | Strap pin: 0 selects address 000001, 1 selects address 000010 |
| sel_o | output | 1 | Device is selected |
| xfer_type_o | output | 2 | Latched transfer type |
| data_oe_o | output | 1 | Output enable for the data line driver |
| xfer_stb_o | output | 1 | One-cycle strobe per data-phase serial clock while selected |
| xfer_bit_o | output | 1 | Data bit sampled with the strobe |

## Verification
The bench sends matching addresses under both strap settings and with several transfer types. This separates the address comparison from the latching of the type and shows how `data_oe_o` follows type bit 1. Byte 0x20 is the bit-reverse of a matching byte and must be rejected, which shows the block takes the least significant bit first. A foreign address, the all-zero dummy address, a byte cut short after three bits, and a matching byte followed by extra clocks show which events change the decision and which leave it alone. Bursts in the data phase, sent while selected and while deselected, check the count of strobes and the order of the bits.

// File: rtl/hab_pkg.sv
package hab_pkg;
  localparam int unsigned TYPE_W   = 2;
  localparam int unsigned DEV_W    = 6;
  localparam int unsigned BYTE_W   = TYPE_W + DEV_W;
  localparam int unsigned READ_BIT = 1;

  typedef logic [TYPE_W-1:0] xfer_type_t;
  typedef logic [DEV_W-1:0]  dev_addr_t;

  typedef struct packed {
    dev_addr_t  dev;
    xfer_type_t kind;
  } addr_byte_t;
endpackage

// File: rtl/hab_sync.sv
module hab_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hab_shifter.sv
module hab_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              mode_i,
  input  logic              data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mode_i) begin
        cnt_q <= '0;
      end else if (rise_i && cnt_q != FULL) begin
        sh_q   <= {data_i, sh_q[BYTE_W-1:1]};
        cnt_q  <= cnt_q + 1'b1;
        done_q <= (cnt_q == LAST);
      end
    end
  end

  assign byte_o = sh_q;
  assign done_o = done_q;

  a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  a_r10_single_done: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r7_done_needs_low_mode: assert property (@(posedge clk) disable iff (rst)
    (mode_i && !done_q) |=> !done_q);
endmodule

// File: rtl/hab_decoder.sv
module hab_decoder
  import hab_pkg::*;
#(
  parameter dev_addr_t ADDR_LO = 6'd1,
  parameter dev_addr_t ADDR_HI = 6'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       done_i,
  input  addr_byte_t byte_i,
  input  logic       addr_sel_i,
  output logic       sel_o,
  output xfer_type_t type_o,
  output logic       oe_o
);
  dev_addr_t  own_addr;
  logic       match;
  logic       sel_q, oe_q;
  xfer_type_t type_q;

  assign own_addr = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign match    = (byte_i.dev == own_addr) && (byte_i.dev != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      oe_q   <= 1'b0;
      type_q <= '0;
    end else if (done_i) begin
      if (match) begin
        sel_q  <= 1'b1;
        type_q <= byte_i.kind;
        oe_q   <= byte_i.kind[READ_BIT];
      end else begin
        sel_q  <= 1'b0;
        type_q <= '0;
        oe_q   <= 1'b0;
      end
    end
  end

  assign sel_o  = sel_q;
  assign type_o = type_q;
  assign oe_o   = oe_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sel_q && !oe_q && type_q == '0));
  a_r6_dummy_deselects: assert property (@(posedge clk) disable iff (rst)
    (done_i && byte_i.dev == '0) |=> (!sel_q && !oe_q));
  a_r5_mismatch_releases: assert property (@(posedge clk) disable iff (rst)
    (done_i && byte_i.dev != own_addr) |=> (!sel_q && !oe_q));
  a_r7_hold_without_done: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> ($stable(sel_q) && $stable(type_q) && $stable(oe_q)));
endmodule

// File: rtl/hab_top.sv
module hab_top
  import hab_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter dev_addr_t   ADDR_LO     = 6'd1,
  parameter dev_addr_t   ADDR_HI     = 6'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sclk_i,
  input  logic              bus_mode_i,
  input  logic              bus_data_i,
  input  logic              addr_sel_i,
  output logic              sel_o,
  output logic [TYPE_W-1:0] xfer_type_o,
  output logic              data_oe_o,
  output logic              xfer_stb_o,
  output logic              xfer_bit_o
);
  localparam int unsigned BUS_W = 3;

  logic [BUS_W-1:0] bus_s;
  logic s_sclk, s_mode, s_data;
  logic sclk_d_q, rise;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_done;
  logic sel;
  logic stb_q, bit_q;

  hab_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({bus_sclk_i, bus_mode_i, bus_data_i}),
    .dout (bus_s)
  );

  assign {s_sclk, s_mode, s_data} = bus_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d_q <= 1'b0;
    else     sclk_d_q <= s_sclk;
  end

  assign rise = s_sclk && !sclk_d_q;

  hab_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .mode_i (s_mode),
    .data_i (s_data),
    .byte_o (rx_byte),
    .done_o (rx_done)
  );

  hab_decoder #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .done_i     (rx_done),
    .byte_i     (addr_byte_t'(rx_byte)),
    .addr_sel_i (addr_sel_i),
    .sel_o      (sel),
    .type_o     (xfer_type_o),
    .oe_o       (data_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      stb_q <= sel && rise && s_mode;
      if (rise) bit_q <= s_data;
    end
  end

  assign sel_o      = sel;
  assign xfer_stb_o = stb_q;
  assign xfer_bit_o = bit_q;

  a_r9_stb_only_selected: assert property (@(posedge clk) disable iff (rst)
    xfer_stb_o |-> $past(sel_o));
  a_r9_stb_single: assert property (@(posedge clk) disable iff (rst)
    xfer_stb_o |=> !xfer_stb_o);
  a_r8_oe_follows_sel: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_o) |-> !data_oe_o);
endmodule

// File: tb/hab_top_tb.sv
module hab_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_BIT   = 4;
  localparam int  SETTLE     = 10;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, mode = 1'b1, data = 1'b0, asel = 1'b0;
  logic sel, oe, stb, sbit;
  logic [1:0] ty;

  always #(CLK_PERIOD/2) clk = ~clk;

  hab_top dut_i (
    .clk (clk), .rst (rst),
    .bus_sclk_i (sclk), .bus_mode_i (mode), .bus_data_i (data),
    .addr_sel_i (asel),
    .sel_o (sel), .xfer_type_o (ty), .data_oe_o (oe),
    .xfer_stb_o (stb), .xfer_bit_o (sbit)
  );

  typedef struct {
    string      req;
    bit         is_burst;
    logic [3:0] st;
    int         cnt;
    logic [7:0] bits;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int pulse_cnt = 0;
  logic [7:0] pulse_bits = '0;
  bit done_flag = 0;

  always @(negedge clk) begin
    if (stb) begin
      pulse_cnt++;
      pulse_bits = {sbit, pulse_bits[7:1]};
    end
  end

  // monitor: pops expected items and compares with the outputs
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (e.is_burst) begin
        if (pulse_cnt != e.cnt || pulse_bits != e.bits) begin
          n_bad++;
          $display("FAIL %s: pulses=%0d bits=%h expected pulses=%0d bits=%h",
                   e.req, pulse_cnt, pulse_bits, e.cnt, e.bits);
        end
      end else if ({sel, oe, ty} !== e.st) begin
        n_bad++;
        $display("FAIL %s: {sel,oe,type}=%b expected %b", e.req, {sel, oe, ty}, e.st);
      end
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic push_st(input string r, input logic s, input logic o, input logic [1:0] t);
    exp_t e;
    e.req = r; e.is_burst = 0; e.st = {s, o, t}; e.cnt = 0; e.bits = '0;
    exp_q.push_back(e);
    wait_clk(2);
  endtask

  task automatic clock_bit(input logic b);
    data = b; sclk = 1'b0;
    wait_clk(HALF_BIT);
    sclk = 1'b1;
    wait_clk(HALF_BIT);
  endtask

  // sends n bits of v, bit 0 first, in an addressing phase
  task automatic send_addr(input logic [7:0] v, input int n, input int extra);
    mode = 1'b0;
    wait_clk(HALF_BIT);
    for (int i = 0; i < n; i++) clock_bit(v[i]);
    for (int i = 0; i < extra; i++) clock_bit(1'b1);
    mode = 1'b1;
    wait_clk(SETTLE);
  endtask

  task automatic burst(input string r, input logic [7:0] v, input int n, input int exp_n);
    exp_t e;
    wait_clk(1);
    pulse_cnt = 0; pulse_bits = '0;
    mode = 1'b1;
    for (int i = 0; i < n; i++) clock_bit(v[i]);
    wait_clk(SETTLE);
    e.req = r; e.is_burst = 1; e.st = '0; e.cnt = exp_n;
    e.bits = (exp_n == 0) ? 8'h00 : 8'((v << (8 - exp_n)) & 8'hFF);
    exp_q.push_back(e);
    wait_clk(2);
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(SETTLE);
    push_st("R1 reset state", 0, 0, 2'b00);
    burst("R1 no strobe after reset", 8'h0F, 4, 0);

    asel = 1'b0;
    send_addr(8'h05, 8, 0);
    push_st("R3 match lo addr type01", 1, 0, 2'b01);
    burst("R9 selected data burst", 8'h0D, 5, 5);

    send_addr(8'h07, 8, 0);
    push_st("R8 read type drives oe", 1, 1, 2'b11);

    send_addr(8'h08, 8, 0);
    push_st("R5 other addr deselects", 0, 0, 2'b00);
    burst("R9 no strobe when deselected", 8'h05, 3, 0);

    asel = 1'b1;
    send_addr(8'h0A, 8, 0);
    push_st("R4 match hi addr type10", 1, 1, 2'b10);

    send_addr(8'h00, 3, 0);
    push_st("R7 truncated byte ignored", 1, 1, 2'b10);

    send_addr(8'h00, 8, 0);
    push_st("R6 dummy addr deselects", 0, 0, 2'b00);

    send_addr(8'h09, 8, 3);
    push_st("R10 extra clocks ignored", 1, 0, 2'b01);
    burst("R9 eight bit burst order", 8'hA6, 8, 8);

    asel = 1'b0;
    send_addr(8'h04, 8, 0);
    push_st("R3 match lo type00", 1, 0, 2'b00);
    send_addr(8'h20, 8, 0);
    push_st("R2 reversed order rejected", 0, 0, 2'b00);

    wait_clk(SETTLE);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule